// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking a four-level hierarchy of translation tables held in memory. Each table has 512 entries of 64 bits. A request carries the virtual address and the table-root register. Before any memory traffic, the walker checks that the address is in canonical form. It then fetches one entry per level through a single 64-bit read port with a valid/ready handshake. The walk ends with a physical address of up to 52 bits, a page fault, or a non-canonical fault.

Leaf mappings can occur at three depths:
- A 1GB page at the second level from the top.
- A 2MB page at the directory level.
- A 4KB page at the last level.

The result also reports the size of the mapped page. The walker serves one request at a time. A new request is accepted only after the previous result has been shown for one cycle.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_valid` is 0.
- R2: An address is canonical only when bits 63:48 all match bit 47. A non-canonical address returns `rsp_fault` = 2 with `rsp_paddr` = 0 and `rsp_size` = 0, and issues no memory read.
- R3: Each entry is read at the address formed by three parts, from high to low: bits 51:12 of the current base, then the 9-bit index, then three zero bits. At the top level the base is the root register, and bits 11:0 of the root are ignored. The index comes from a different slice of the virtual address at each level:
  - top level: bits 47:39
  - second level: bits 38:30
  - directory level: bits 29:21
  - last level: bits 20:12
- R4: A present last-level entry ends the walk with `rsp_fault` = 0 and `rsp_size` = 0. The physical address is entry bits 51:12 followed by address bits 11:0. Entry bits 63:52 do not affect the result.
- R5: A present directory entry with bit 7 set ends the walk after three reads with `rsp_size` = 1. The physical address is entry bits 51:21 followed by address bits 20:0.
- R6: A present second-level entry with bit 7 set ends the walk after two reads with `rsp_size` = 2. The physical address is entry bits 51:30 followed by address bits 29:0.
- R7: An entry with bit 0 clear, at any level, stops the walk at once with `rsp_fault` = 1, `rsp_paddr` = 0 and `rsp_size` = 0. No further read is issued for that request.
- R8: Bit 7 of a top-level entry is ignored, and the walk descends normally.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the result is shown. `rsp_valid` is a single-cycle pulse.
- R10: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen high. Each fetched entry arrives on a later cycle with `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root register; bits 51:12 locate the top table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 52 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Returned 64-bit entry |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 non-canonical |
| rsp_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |

## Verification
A wrong level counter or a stale table base shows up at the ports in two ways. First, the read count per request is wrong. Second, the entry addresses are wrong, so the model memory returns empty entries, and a page fault appears in place of the expected physical address within a few cycles of the bad read. A faulty leaf decision shows up in the same result pulse, as a wrong size code or wrong low address bits. A broken canonical check shows up within one cycle, either as a read issued for an address that should be rejected or as an early fault code. Stalling the read handshake exposes a walker that moves its address or drops its request while the memory is not ready.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_PAGE     = 2'd1,
      FLT_NONCANON = 2'd2
   } fault_e;

   typedef enum logic [1:0] {
      SZ_4K = 2'd0,
      SZ_2M = 2'd1,
      SZ_1G = 2'd2
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } walk_state_e;

endpackage

// File: rtl/pt_canon_chk.sv
module pt_canon_chk #(
   parameter int XLEN = 64,
   parameter int VA_W = 48
) (
   input  logic [XLEN-1:0] va,
   output logic            canon_ok
);
   if (VA_W > XLEN || VA_W < 2) begin : g_bad_width
      $error("pt_canon_chk: VA_W must lie in 2..XLEN");
   end

   if (VA_W == XLEN) begin : g_full
      assign canon_ok = 1'b1;
   end else begin : g_sext
      localparam int TOP_W = XLEN - VA_W + 1;
      logic [TOP_W-1:0] top_bits;
      assign top_bits = va[XLEN-1:VA_W-1];
      assign canon_ok = (&top_bits) | ~(|top_bits);
   end
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
   parameter int XLEN   = 64,
   parameter int PA_W   = 52,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 9,
   parameter int LEVELS = 4,
   localparam int BASE_W = PA_W - OFF_W,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [BASE_W-1:0] base,
   input  logic [XLEN-1:0]   va,
   input  logic [LVL_W-1:0]  lvl,
   output logic [PA_W-1:0]   addr
);
   localparam int PAD_W = OFF_W - IDX_W;

   if (PAD_W < 1) begin : g_bad_pad
      $error("pt_entry_addr: entry size must leave zero padding bits");
   end
   if (OFF_W + IDX_W * LEVELS > XLEN) begin : g_bad_span
      $error("pt_entry_addr: index fields exceed the address width");
   end

   logic [IDX_W-1:0] idx [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_idx
      assign idx[l] = va[OFF_W + IDX_W*l +: IDX_W];
   end

   assign addr = {base, idx[lvl], {PAD_W{1'b0}}};
endmodule

// File: rtl/pt_leaf_compose.sv
module pt_leaf_compose #(
   parameter int XLEN   = 64,
   parameter int PA_W   = 52,
   parameter int ENT_W  = 64,
   parameter int OFF_W  = 12,
   parameter int IDX_W  = 9,
   parameter int LEVELS = 4,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [XLEN-1:0]  va,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  paddr,
   output logic [1:0]       size
);
   logic [PA_W-1:0] cand [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_cand
      localparam int SH = OFF_W + IDX_W*l;
      if (SH >= PA_W) begin : g_bad_shift
         $error("pt_leaf_compose: page offset wider than physical address");
      end else begin : g_ok
         assign cand[l] = {entry[PA_W-1:SH], va[SH-1:0]};
      end
   end

   assign paddr = cand[lvl];
   assign size  = 2'(lvl);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int VA_W        = 48,
   parameter int PA_W        = 52,
   parameter int ENT_W       = 64,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 9,
   parameter int LEVELS      = 4,
   parameter int PRESENT_BIT = 0,
   parameter int LEAF_BIT    = 7,
   parameter logic [LEVELS-1:0] BIG_PAGE_LVLS = 4'b0110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [XLEN-1:0]  req_vaddr,
   input  logic [XLEN-1:0]  req_root,
   output logic             mem_rd_valid,
   input  logic             mem_rd_ready,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rsp_valid,
   input  logic [ENT_W-1:0] mem_rsp_data,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [1:0]       rsp_fault,
   output logic [1:0]       rsp_size
);
   localparam int BASE_W  = PA_W - OFF_W;
   localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int TOP_LVL = LEVELS - 1;

   if (OFF_W + IDX_W * LEVELS != VA_W) begin : g_bad_split
      $error("pt_walker: offset plus indices must equal VA_W");
   end
   if (PA_W > ENT_W || PA_W > XLEN) begin : g_bad_pa
      $error("pt_walker: PA_W must fit in an entry and in the root");
   end
   if (LEVELS > 4 || LEVELS < 2) begin : g_bad_levels
      $error("pt_walker: size code holds at most four levels");
   end
   if (LEAF_BIT >= OFF_W || PRESENT_BIT >= OFF_W) begin : g_bad_flags
      $error("pt_walker: flag bits must sit below the base field");
   end

   walk_state_e           state;
   logic [LVL_W-1:0]      lvl;
   logic [BASE_W-1:0]     base_q;
   logic [XLEN-1:0]       va_q;
   logic [PA_W-1:0]       paddr_q;
   logic [1:0]            fault_q;
   logic [1:0]            size_q;

   logic                  canon_ok;
   logic [PA_W-1:0]       leaf_pa;
   logic [1:0]            leaf_sz;
   logic                  ent_present;
   logic                  ent_leaf;

   pt_canon_chk #(.XLEN(XLEN), .VA_W(VA_W)) u_canon (
      .va       (req_vaddr),
      .canon_ok (canon_ok)
   );

   pt_entry_addr #(
      .XLEN(XLEN), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
   ) u_eaddr (
      .base (base_q),
      .va   (va_q),
      .lvl  (lvl),
      .addr (mem_rd_addr)
   );

   pt_leaf_compose #(
      .XLEN(XLEN), .PA_W(PA_W), .ENT_W(ENT_W), .OFF_W(OFF_W),
      .IDX_W(IDX_W), .LEVELS(LEVELS)
   ) u_leaf (
      .entry (mem_rsp_data),
      .va    (va_q),
      .lvl   (lvl),
      .paddr (leaf_pa),
      .size  (leaf_sz)
   );

   assign ent_present = mem_rsp_data[PRESENT_BIT];
   assign ent_leaf    = (lvl == '0) || (mem_rsp_data[LEAF_BIT] && BIG_PAGE_LVLS[lvl]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         lvl     <= '0;
         base_q  <= '0;
         va_q    <= '0;
         paddr_q <= '0;
         fault_q <= FLT_NONE;
         size_q  <= SZ_4K;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  base_q <= req_root[PA_W-1:OFF_W];
                  lvl    <= LVL_W'(TOP_LVL);
                  if (!canon_ok) begin
                     paddr_q <= '0;
                     size_q  <= SZ_4K;
                     fault_q <= FLT_NONCANON;
                     state   <= ST_DONE;
                  end else begin
                     state <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_rd_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     paddr_q <= '0;
                     size_q  <= SZ_4K;
                     fault_q <= FLT_PAGE;
                     state   <= ST_DONE;
                  end else if (ent_leaf) begin
                     paddr_q <= leaf_pa;
                     size_q  <= leaf_sz;
                     fault_q <= FLT_NONE;
                     state   <= ST_DONE;
                  end else begin
                     base_q <= mem_rsp_data[PA_W-1:OFF_W];
                     lvl    <= lvl - 1'b1;
                     state  <= ST_ISSUE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state == ST_IDLE);
   assign mem_rd_valid = (state == ST_ISSUE);
   assign rsp_valid    = (state == ST_DONE);
   assign rsp_paddr    = paddr_q;
   assign rsp_fault    = fault_q;
   assign rsp_size     = size_q;

   assert_noncanon_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !canon_ok) |=> (rsp_valid && rsp_fault == FLT_NONCANON && !mem_rd_valid));

   assert_offset_4k_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

   assert_size_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_size != 2'd3));

   assert_offset_2m_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_NONE && rsp_size == SZ_2M)
         |-> (rsp_paddr[OFF_W+IDX_W-1:0] == va_q[OFF_W+IDX_W-1:0]));

   assert_offset_1g_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_NONE && rsp_size == SZ_1G)
         |-> (rsp_paddr[OFF_W+2*IDX_W-1:0] == va_q[OFF_W+2*IDX_W-1:0]));

   assert_fault_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0 && rsp_size == SZ_4K));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [63:0] req_vaddr;
   logic [63:0] req_root;
   logic        mem_rd_valid;
   logic        mem_rd_ready;
   logic [51:0] mem_rd_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        rsp_valid;
   logic [51:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic [1:0]  rsp_size;

   int checks = 0;
   int fails  = 0;
   int rd_cnt = 0;
   int addr_err = 0;
   int busy_err = 0;
   int cycles = 0;
   logic stall_en = 1'b0;
   logic pend = 1'b0;
   logic [51:0] pend_addr = '0;

   logic [63:0] mem [logic [51:0]];

   always #4 clk = ~clk;

   pt_walker dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_root(req_root),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_fault(rsp_fault), .rsp_size(rsp_size)
   );

   typedef struct packed {
      logic [63:0] va;
      logic [63:0] root;
      logic [51:0] pa;
      logic [1:0]  flt;
      logic [1:0]  sz;
      logic [3:0]  nrd;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{64'h0000_0080_8060_4123, 64'h1000, 52'hF_EDCB_A987_6123, 2'd0, 2'd0, 4'd4},
      '{64'h0000_0080_80A1_2345, 64'h1000, 52'h0_0012_3461_2345, 2'd0, 2'd1, 4'd3},
      '{64'h0000_0081_D234_5678, 64'h1ABC, 52'h0_0050_1234_5678, 2'd0, 2'd2, 4'd2},
      '{64'h0000_0080_8060_6000, 64'h1000, 52'h0,                2'd1, 2'd0, 4'd4},
      '{64'h0000_0180_0000_0000, 64'h1000, 52'h0,                2'd1, 2'd0, 4'd1},
      '{64'h0000_0082_4000_0000, 64'h1000, 52'h0,                2'd1, 2'd0, 4'd2},
      '{64'hFFFF_8000_8060_4456, 64'h1000, 52'hF_EDCB_A987_6456, 2'd0, 2'd0, 4'd4},
      '{64'h0001_0000_0000_0000, 64'h1000, 52'h0,                2'd2, 2'd0, 4'd0},
      '{64'hFFFF_0000_0000_0000, 64'h1000, 52'h0,                2'd2, 2'd0, 4'd0},
      '{64'h0000_8000_0000_0000, 64'h1000, 52'h0,                2'd2, 2'd0, 4'd0},
      '{64'h0000_0200_8060_4789, 64'h1000, 52'hF_EDCB_A987_6789, 2'd0, 2'd0, 4'd4}
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3, 4, 5: return "R7";
         6: return "R3";
         7, 8, 9: return "R2";
         default: return "R8";
      endcase
   endfunction

   // memory responder: accepts reads, returns the entry one cycle later
   initial begin
      mem_rd_ready  = 1'b1;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(posedge clk);
         if (pend && mem_rd_valid && mem_rd_addr != pend_addr) addr_err = addr_err + 1;
         if (pend && !mem_rd_valid) addr_err = addr_err + 1;
         pend      = mem_rd_valid && !mem_rd_ready;
         pend_addr = mem_rd_addr;
         if (mem_rd_valid && mem_rd_ready) begin
            rd_cnt = rd_cnt + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'h0;
         end else begin
            mem_rsp_valid <= 1'b0;
         end
         mem_rd_ready <= stall_en ? ~mem_rd_ready : 1'b1;
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles = cycles + 1;
         if (cycles > 20000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 20000", cycles);
            finish_run();
         end
      end
   end

   task automatic walk(input logic [63:0] va, input logic [63:0] root,
                       output logic [51:0] pa, output logic [1:0] flt,
                       output logic [1:0] sz, output int nrd);
      @(negedge clk);
      rd_cnt    = 0;
      req_valid = 1'b1;
      req_vaddr = va;
      req_root  = root;
      @(negedge clk);
      req_valid = 1'b0;
      for (int w = 0; w < 200 && !rsp_valid; w++) begin
         if (req_ready) busy_err = busy_err + 1;
         @(negedge clk);
      end
      pa  = rsp_paddr;
      flt = rsp_fault;
      sz  = rsp_size;
      nrd = rd_cnt;
      @(negedge clk);
      if (rsp_valid || !req_ready) busy_err = busy_err + 1;
   endtask

   logic [51:0] a_pa;
   logic [1:0]  a_flt;
   logic [1:0]  a_sz;
   int          a_nrd;

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_vaddr = '0;
      req_root  = '0;
      mem[52'h1008] = 64'h0000_0000_0000_2001;
      mem[52'h1800] = 64'h0000_0000_0000_2001;
      mem[52'h1020] = 64'h0000_0000_0000_2081;
      mem[52'h2010] = 64'h0000_0000_0000_3001;
      mem[52'h2038] = 64'h0000_0050_0000_0081;
      mem[52'h3018] = 64'h0000_0000_0000_4001;
      mem[52'h3028] = 64'h0000_0012_3460_0081;
      mem[52'h4020] = 64'h800F_EDCB_A987_6003;

      repeat (3) @(negedge clk);
      // R1: state while reset is held
      checks = checks + 1;
      if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_rd_valid !== 1'b0) begin
         fails = fails + 1;
         $display("FAIL R1 in reset: actual ready=%b rsp=%b rd=%b expected 1 0 0",
                  req_ready, rsp_valid, mem_rd_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks = checks + 1;
      if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_rd_valid !== 1'b0) begin
         fails = fails + 1;
         $display("FAIL R1 after reset: actual ready=%b rsp=%b rd=%b expected 1 0 0",
                  req_ready, rsp_valid, mem_rd_valid);
      end

      for (int i = 0; i < NV; i++) begin
         walk(VECS[i].va, VECS[i].root, a_pa, a_flt, a_sz, a_nrd);
         checks = checks + 1;
         if (a_pa !== VECS[i].pa || a_flt !== VECS[i].flt || a_sz !== VECS[i].sz) begin
            fails = fails + 1;
            $display("FAIL %s vec %0d: actual pa=%h flt=%0d sz=%0d expected pa=%h flt=%0d sz=%0d",
                     tag_of(i), i, a_pa, a_flt, a_sz, VECS[i].pa, VECS[i].flt, VECS[i].sz);
         end
         checks = checks + 1;
         if (a_nrd != int'(VECS[i].nrd)) begin
            fails = fails + 1;
            $display("FAIL %s vec %0d reads: actual %0d expected %0d",
                     tag_of(i), i, a_nrd, VECS[i].nrd);
         end
      end

      // R10: read handshake with memory stalling every other cycle
      stall_en = 1'b1;
      walk(64'h0000_0080_8060_4123, 64'h1000, a_pa, a_flt, a_sz, a_nrd);
      checks = checks + 1;
      if (a_pa !== 52'hF_EDCB_A987_6123 || a_flt !== 2'd0 || a_nrd != 4) begin
         fails = fails + 1;
         $display("FAIL R10 stalled walk: actual pa=%h flt=%0d reads=%0d expected pa=fedcba9876123 flt=0 reads=4",
                  a_pa, a_flt, a_nrd);
      end
      walk(64'h0000_0080_80A1_2345, 64'h1000, a_pa, a_flt, a_sz, a_nrd);
      checks = checks + 1;
      if (a_pa !== 52'h0_0012_3461_2345 || a_sz !== 2'd1 || a_nrd != 3) begin
         fails = fails + 1;
         $display("FAIL R10 stalled 2MB walk: actual pa=%h sz=%0d reads=%0d expected pa=12346112345 sz=1 reads=3",
                  a_pa, a_sz, a_nrd);
      end
      stall_en = 1'b0;
      checks = checks + 1;
      if (addr_err != 0) begin
         fails = fails + 1;
         $display("FAIL R10 address or valid moved while stalled: actual %0d events expected 0", addr_err);
      end

      // R9: busy while walking, single-cycle result pulse
      checks = checks + 1;
      if (busy_err != 0) begin
         fails = fails + 1;
         $display("FAIL R9 ready/pulse violations: actual %0d expected 0", busy_err);
      end

      finish_run();
   end
endmodule